// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is an I2C target that serves reads from an 11-bit addressed byte array (2048 bytes). A controller sets the read position with a write-direction header and one byte-address byte. It then issues a repeated START and a read-direction header, and the target streams bytes from that position. Each acknowledge from the controller after a byte moves the target to the next address. A controller that omits the address phase reads from wherever the internal pointer was left.

The SCL and SDA lines are sampled on the system clock. The only drive back onto the bus is an open-drain pull-down enable for SDA. A supervisor reset-active flag mutes the target completely, so it acknowledges nothing while that flag is high. Write traffic only positions the pointer; nothing is programmed into the array. A synchronous load port fills the array before use.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After a write header (type code 4'b1010 in header bits 7:4, bit 0 = 0), an acknowledged address byte, a repeated START and a read header (bit 0 = 1), the target acknowledges every header and address byte and returns the byte stored at the selected address.
- R2: Data bytes leave the target most significant bit first. SDA changes only while SCL is low, except when a START, a STOP or the reset-active flag forces it.
- R3: A data byte answered with no acknowledge, followed by a STOP, ends the transfer: SDA is released and busy drops low.
- R4: Each controller acknowledge after a data byte makes the next byte come from the address one higher.
- R5: The address pointer spans all 11 bits; after address 2047 the next byte comes from address 0, and streaming continues.
- R6: A read header that follows a START with no address phase returns data starting at the address after the last byte sent.
- R7: While the reset-active input is high, the target acknowledges no header and no byte, and it drives SDA in no cycle after the first.
- R8: A write header carries address bits 10:8 in its bits 3:1, and the address byte carries bits 7:0. Bits 3:1 of a read header leave the pointer unchanged.
- R9: A header whose bits 7:4 differ from 4'b1010 is not acknowledged, and neither is any later byte before the next START.
- R10: A START detected at any point aborts the current transfer and begins a new header. A STOP returns the target to idle.
- R11: After reset the target is idle, with busy low and SDA released. The load port writes one byte per clock into the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| sup_reset | input | 1 | Reset-active flag from the supervisor; mutes the target |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | High to pull SDA low (open-drain drive) |
| busy | output | 1 | High from a START until the next STOP |
| load_en | input | 1 | Write strobe for filling the array |
| load_addr | input | 11 | Array address for the fill write |
| load_data | input | 8 | Byte written by the fill port |

## Verification
Random reads sweep all eight values of the upper address bits against six low-byte values, including 0x00 and 0xFF. This tells apart header-carried bits from address-byte bits, and a swapped or dropped bit shows up as the wrong pattern byte. A five-byte stream from 2045 crosses the top of the array, which separates a full 11-bit counter from one that wraps at 256 or stops. An immediate read afterwards, sent with nonzero header bits 3:1, shows whether the pointer was kept and the read header left it alone. Muted, mismatched and aborted headers each check that the acknowledge bit reads high while a following clean transfer still returns correct data.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } rd_state_t;

  // header type field compare
  function automatic logic hdr_match(input logic [7:0] hdr, input logic [3:0] code);
    return hdr[7:4] == code;
  endfunction

  // direction bit of a header: 1 = read
  function automatic logic hdr_is_read(input logic [7:0] hdr);
    return hdr[0];
  endfunction

endpackage

// File: rtl/i2c_rd_lines.sv
module i2c_rd_lines (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_m, scl_q;
  logic sda_m, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      scl_q <= 1'b1;
      sda_m <= 1'b1;
      sda_s <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= scl_in;
      scl_s <= scl_m;
      scl_q <= scl_s;
      sda_m <= sda_in;
      sda_s <= sda_m;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    rd_data <= cells[rd_addr];
  end

endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter int         AW       = 11,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_reset,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          ptr_adv,
  output logic          sda_pull,
  output logic          busy,
  output rd_state_t     state
);

  localparam int HI_W = AW - 8;

  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       mack;
  logic       byte_done;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return p + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  assign byte_done = scl_fall && (cnt == 4'd8);

  // a new data byte is fetched and the pointer stepped
  assign ptr_adv = scl_fall && !sup_reset && !start_evt && !stop_evt &&
                   ((state == ST_DEV_ACK && hdr_is_read(shreg)) ||
                    (state == ST_TX_ACK && mack));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      shreg <= 8'h00;
      cnt   <= 4'd0;
      mack  <= 1'b0;
      ptr   <= '0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
    end else if (start_evt) begin
      state <= ST_DEV;
      cnt   <= 4'd0;
    end else if (sup_reset && state != ST_IDLE) begin
      state <= ST_WAIT;
    end else begin
      if (ptr_adv) begin
        shreg <= rd_data;
        cnt   <= 4'd0;
        ptr   <= next_ptr(ptr);
        state <= ST_TX;
      end else begin
        unique case (state)
          ST_DEV: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              state <= hdr_match(shreg, DEV_CODE) ? ST_DEV_ACK : ST_WAIT;
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              cnt   <= 4'd0;
              ptr[AW-1:8] <= shreg[HI_W:1];
              state <= ST_ADDR;
            end
          end
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              ptr[7:0] <= shreg;
              state    <= ST_ADDR_ACK;
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) state <= ST_WAIT;
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                cnt   <= 4'd0;
                state <= ST_TX_ACK;
              end else begin
                shreg <= {shreg[6:0], 1'b1};
                cnt   <= cnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) state <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull = (state == ST_DEV_ACK) || (state == ST_ADDR_ACK) ||
                    (state == ST_TX && !shreg[7]);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader
  import i2c_rd_pkg::*;
#(
  parameter int         AW       = 11,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_reset,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull,
  output logic          busy,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [7:0]    load_data
);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [AW-1:0] rd_ptr;
  logic          ptr_adv;
  logic [7:0]    rd_data;
  rd_state_t     ctrl_state;

  i2c_rd_lines u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_rd_mem #(.AW(AW), .DW(8)) u_mem (
    .clk     (clk),
    .wr_en   (load_en),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_addr (rd_ptr),
    .rd_data (rd_data)
  );

  i2c_rd_ctrl #(.AW(AW), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_reset (sup_reset),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .ptr       (rd_ptr),
    .ptr_adv   (ptr_adv),
    .sda_pull  (sda_pull),
    .busy      (busy),
    .state     (ctrl_state)
  );

endmodule

// File: rtl/i2c_rd_checker.sv
module i2c_rd_checker
  import i2c_rd_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sup_reset,
  input logic          sda_pull,
  input logic          busy,
  input logic          scl_s,
  input logic          start_evt,
  input logic          stop_evt,
  input logic [AW-1:0] ptr,
  input logic          ptr_adv,
  input rd_state_t     state
);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |->
      (!scl_s || $past(sup_reset) || $past(start_evt) || $past(stop_evt))); // R2

  AST_STOP_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv |=> (ptr == $past(ptr) + AW'(1))); // R4

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && ptr == {AW{1'b1}}) |=> (ptr == '0)); // R5

  AST_MUTED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sup_reset |=> !sda_pull); // R7

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !stop_evt) |=> (state == ST_DEV)); // R10

endmodule

bind i2c_eeprom_reader i2c_rd_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sup_reset (sup_reset),
  .sda_pull  (sda_pull),
  .busy      (busy),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .ptr       (rd_ptr),
  .ptr_adv   (ptr_adv),
  .state     (ctrl_state)
);

// File: tb/i2c_eeprom_reader_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_reader_bench;

  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_reset = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull, busy;
  logic load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [7:0] load_data = '0;
  wire sda_line = m_sda & ~sda_pull;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_eeprom_reader u_i2c_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .sup_reset(sup_reset),
    .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .busy(busy),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data)
  );

  function automatic logic [7:0] pat(input int a);
    int v;
    v = (a * 37) + ((a >> 8) * 11) + 5;
    return 8'(v & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic q();
    wclk(5);
  endtask

  task automatic bit_out(input logic b);
    m_scl = 1'b0; q(); m_sda = b; q(); m_scl = 1'b1; q(); q();
  endtask

  task automatic bit_in(output logic b);
    m_scl = 1'b0; q(); m_sda = 1'b1; q(); m_scl = 1'b1; q(); b = sda_line; q();
  endtask

  task automatic do_start();
    m_scl = 1'b0; q(); m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q();
  endtask

  task automatic do_stop();
    m_scl = 1'b0; q(); m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
  endtask

  // full random read of n bytes from address a
  task automatic rand_read(input int a, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    logic [2:0] hi;
    hi = 3'((a >> 8) & 7);
    do_start();
    send_byte({4'b1010, hi, 1'b0}, ack);
    check(ack, "R1 write header ack", ack, 1);
    send_byte(8'(a & 255), ack);
    check(ack, "R1 address byte ack", ack, 1);
    do_start();
    send_byte({4'b1010, hi, 1'b1}, ack);
    check(ack, "R1 read header ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, d);
      check(d == pat((a + i) % DEPTH), tag, d, pat((a + i) % DEPTH));
    end
    do_stop();
  endtask

  initial begin
    wclk(190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    wclk(4);
    rst_n = 1'b1;
    wclk(2);
    // R11 reset state
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(sda_pull == 1'b0, "R11 sda released after reset", sda_pull, 0);

    // R11 fill the array through the load port
    for (int a = 0; a < DEPTH; a++) begin
      load_en = 1'b1; load_addr = AW'(a); load_data = pat(a);
      wclk(1);
    end
    load_en = 1'b0;
    wclk(2);

    // R1 R2 R4 R8 sweep of upper bits and low byte
    for (int hi = 0; hi < 8; hi++) begin
      for (int k = 0; k < 6; k++) begin
        rand_read(hi * 256 + ((k == 5) ? 255 : k * 51), 2, "R1 R2 R4 R8 data");
      end
    end

    // R5 wrap across the top of the array
    rand_read(2045, 5, "R5 R4 wrap stream");
    // R3 released and idle after NACK and STOP
    check(busy == 1'b0, "R3 busy after stop", busy, 0);
    check(sda_pull == 1'b0, "R3 sda released", sda_pull, 0);

    // R6 immediate read continues at 2; R8 header bits 3:1 ignored on read
    do_start();
    send_byte({4'b1010, 3'b101, 1'b1}, ack);
    check(ack, "R6 immediate read header ack", ack, 1);
    read_byte(1'b1, d);
    check(d == pat(2), "R6 R8 immediate first byte", d, pat(2));
    read_byte(1'b0, d);
    check(d == pat(3), "R6 immediate second byte", d, pat(3));
    do_stop();

    // R7 muted target
    sup_reset = 1'b1;
    wclk(3);
    do_start();
    send_byte(8'hA0, ack);
    check(!ack, "R7 header while muted", ack, 0);
    send_byte(8'h10, ack);
    check(!ack, "R7 byte while muted", ack, 0);
    check(sda_pull == 1'b0, "R7 no drive while muted", sda_pull, 0);
    do_stop();
    // R7 mute during a data byte: bits read back as released
    sup_reset = 1'b0;
    wclk(3);
    do_start();
    send_byte(8'hA1, ack);
    check(ack, "R7 read header before mute", ack, 1);
    sup_reset = 1'b1;
    read_byte(1'b0, d);
    check(d == 8'hFF, "R7 data silenced", d, 8'hFF);
    do_stop();
    sup_reset = 1'b0;
    wclk(3);

    // R9 wrong type code
    do_start();
    send_byte(8'hB0, ack);
    check(!ack, "R9 mismatched header", ack, 0);
    send_byte(8'hA1, ack);
    check(!ack, "R9 no ack before next start", ack, 0);
    do_stop();

    // R10 START aborts an address byte half way
    do_start();
    send_byte(8'hA2, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    rand_read(12'h123, 2, "R10 read after abort");

    // R10 STOP in the middle of a header returns to idle
    do_start();
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    do_stop();
    check(busy == 1'b0, "R10 idle after mid-header stop", busy, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule